// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Data Memory

This block is a synchronous data store for a processor's load/store path. Each address names one 8-bit byte. Accesses are byte, half-word or word sized and travel over a 32-bit data port. Multi-byte values are assembled most-significant-byte first: the byte at the lowest address lands in the top bits of the value. So bytes 0xAA, 0x15, 0x13 and 0xFF stored at addresses 0 to 3 read back as the word 0xAA1513FF.

The store is built from four byte-wide banks, one per address offset within a word. Sub-word stores drive only the enables of the banks they touch. Every cycle the addressed word is read and then formatted: the lane is selected, the value is extended to 32 bits, and an access that breaks alignment is flagged. A misaligned access never changes memory, and its read data is forced to zero. The block has no state machine. Its only sequential elements are the banks and a single stage of registered request attributes.

Top module: `be_data_mem`

## Requirements
- R1: While `rst_n` is low, `rd_data` and `misalign` are both zero.
- R2: A word read (`size`=2'b10) at an address that is a multiple of 4 returns the four bytes at that address and the three after it, with the lowest-addressed byte in bits 31:24. For example, bytes AA,15,13,FF give 0xAA1513FF.
- R3: A half-word read (`size`=2'b01) at an even address returns the byte at that address in bits 15:8 and the next byte in bits 7:0. For the bytes in R2 this gives 0xAA15 at offset 0 and 0x13FF at offset 2.
- R4: A byte read (`size`=2'b00) at any address returns that byte in bits 7:0.
- R5: For byte and half-word reads, `sext`=1 fills the upper bits with the loaded value's top bit, and `sext`=0 fills them with zeros. Word reads ignore `sext`.
- R6: A byte store writes `wr_data[7:0]` to the addressed byte and leaves the other three bytes of the word unchanged.
- R7: A half-word store writes `wr_data[15:8]` to the addressed byte and `wr_data[7:0]` to the next byte, and leaves the other two bytes unchanged.
- R8: `misalign` is 1 in the cycle after each of these requests: a half-word at an odd address, a word at an address that is not a multiple of 4, or the reserved size 2'b11. In that cycle `rd_data` is zero. Byte accesses are never flagged.
- R9: A flagged request with `wr_en`=1 leaves every byte of memory unchanged.
- R10: Read data appears one cycle after the request. A read of the location being written in the same cycle returns the contents from before the write.
- R11: The word at the highest aligned address, 2^ADDR_W-4, is stored and read like any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| addr | input | ADDR_W | Byte address of the request |
| size | input | 2 | Access size: 00 byte, 01 half word, 10 word, 11 reserved |
| wr_en | input | 1 | 1 stores the request's data, 0 only reads |
| wr_data | input | 32 | Store data; sub-word stores use the low-order bits |
| sext | input | 1 | 1 sign-extends, 0 zero-extends sub-word loads |
| rd_data | output | 32 | Formatted load value, one cycle after the request |
| misalign | output | 1 | Alignment violation of the previous cycle's request |

## Verification
The hardest case to reach is a misaligned store whose suppression must be seen at the ports. The flag alone says nothing about whether the banks stayed untouched. The stimulus therefore first fills memory with known contents. It then issues misaligned half-word and word stores, and reserved-size stores, that carry data different from those contents. Each byte the suppressed store would have touched is then read back with aligned loads. Read-before-write is exercised by storing into the same address in consecutive cycles, so each read returns the value from the previous store.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/be_mem_bank.sv
module be_mem_bank #(
    parameter int IDX_W = 8
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [IDX_W-1:0]             idx,
    input  logic [be_mem_pkg::BYTE_W-1:0] wdat,
    output logic [be_mem_pkg::BYTE_W-1:0] q
);
    localparam int DEPTH = 1 << IDX_W;

    logic [be_mem_pkg::BYTE_W-1:0] cells [DEPTH];

    // read-first: q carries the byte held before this edge's write
    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdat;
        end
        q <= cells[idx];
    end

endmodule

// File: rtl/be_mem_store_ctrl.sv
module be_mem_store_ctrl
    import be_mem_pkg::*;
(
    input  logic [1:0]          off,
    input  acc_size_e           sz,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [LANES-1:0]    lane_we,
    output logic [WORD_W-1:0]   lane_data,
    output logic                bad
);
    logic [LANES-1:0] mask;

    always_comb begin
        bad       = 1'b0;
        mask      = '0;
        lane_data = wr_data;
        unique case (sz)
            ACC_BYTE: begin
                mask      = 4'b1000 >> off;
                lane_data = {LANES{wr_data[BYTE_W-1:0]}};
            end
            ACC_HALF: begin
                bad       = off[0];
                mask      = off[1] ? 4'b0011 : 4'b1100;
                lane_data = {2{wr_data[2*BYTE_W-1:0]}};
            end
            ACC_WORD: begin
                bad  = (off != 2'b00);
                mask = 4'b1111;
            end
            ACC_RSVD: begin
                bad  = 1'b1;
                mask = 4'b0000;
            end
        endcase
    end

    // mask bit 3 is offset 0 (most significant lane); remap to bank order
    for (genvar k = 0; k < LANES; k++) begin : g_we
        assign lane_we[k] = wr_en & ~bad & mask[LANES-1-k];
    end

endmodule

// File: rtl/be_mem_load_fmt.sv
module be_mem_load_fmt
    import be_mem_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic [1:0]        off,
    input  acc_size_e         sz,
    input  logic              sext,
    input  logic              bad,
    input  logic              vld,
    output logic [WORD_W-1:0] data
);
    logic [BYTE_W-1:0]   b_sel;
    logic [2*BYTE_W-1:0] h_sel;

    always_comb begin
        b_sel = raw[WORD_W-1-BYTE_W*off -: BYTE_W];
        h_sel = off[1] ? raw[2*BYTE_W-1:0] : raw[WORD_W-1 -: 2*BYTE_W];
    end

    always_comb begin
        data = '0;
        if (vld && !bad) begin
            unique case (sz)
                ACC_BYTE: data = {{(WORD_W-BYTE_W){sext & b_sel[BYTE_W-1]}}, b_sel};
                ACC_HALF: data = {{(WORD_W-2*BYTE_W){sext & h_sel[2*BYTE_W-1]}}, h_sel};
                ACC_WORD: data = raw;
                ACC_RSVD: data = '0;
            endcase
        end
    end

endmodule

// File: rtl/be_data_mem.sv
module be_data_mem #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              sext,
    output logic [31:0]       rd_data,
    output logic              misalign
);
    import be_mem_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    acc_size_e         sz;
    logic [1:0]        off;
    logic [IDX_W-1:0]  idx;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] lane_data;
    logic [WORD_W-1:0] raw;
    logic              bad;

    // registered request attributes, aligned with bank read data
    logic              vld_q;
    logic              bad_q;
    logic [1:0]        off_q;
    acc_size_e         sz_q;
    logic              sext_q;

    assign sz  = acc_size_e'(size);
    assign off = addr[1:0];
    assign idx = addr[ADDR_W-1:2];

    be_mem_store_ctrl i_store (
        .off       (off),
        .sz        (sz),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .lane_we   (lane_we),
        .lane_data (lane_data),
        .bad       (bad)
    );

    // bank k holds byte offset k; big-endian: offset 0 is bits 31:24
    for (genvar k = 0; k < LANES; k++) begin : g_bank
        be_mem_bank #(.IDX_W(IDX_W)) i_bank (
            .clk  (clk),
            .we   (lane_we[k]),
            .idx  (idx),
            .wdat (lane_data[WORD_W-1-BYTE_W*k -: BYTE_W]),
            .q    (raw[WORD_W-1-BYTE_W*k -: BYTE_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            bad_q  <= 1'b0;
            off_q  <= 2'b00;
            sz_q   <= ACC_WORD;
            sext_q <= 1'b0;
        end else begin
            vld_q  <= 1'b1;
            bad_q  <= bad;
            off_q  <= off;
            sz_q   <= sz;
            sext_q <= sext;
        end
    end

    be_mem_load_fmt i_fmt (
        .raw  (raw),
        .off  (off_q),
        .sz   (sz_q),
        .sext (sext_q),
        .bad  (bad_q),
        .vld  (vld_q),
        .data (rd_data)
    );

    assign misalign = vld_q & bad_q;

endmodule

// File: rtl/be_data_mem_chk.sv
module be_data_mem_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        size,
    input logic              sext,
    input logic [31:0]       rd_data,
    input logic              misalign
);
    AST_HALF_ODD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b01 && addr[0]) |=> misalign); // R8

    AST_WORD_OFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b10 && addr[1:0] != 2'b00) |=> misalign); // R8

    AST_BYTE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b00) |=> !misalign); // R8

    AST_FLAG_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (rd_data == 32'h0)); // R8

    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b00 && !sext) |=> (rd_data[31:8] == 24'h0)); // R5

    AST_HALF_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b01 && sext && !addr[0]) |=> (rd_data[31:16] == {16{rd_data[15]}})); // R5

endmodule

bind be_data_mem be_data_mem_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .size     (size),
    .sext     (sext),
    .rd_data  (rd_data),
    .misalign (misalign)
);

// File: tb/test_be_data_mem.sv
module test_be_data_mem;

    localparam int AW    = 10;
    localparam int BYTES = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    size = 2'b10;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          sext = 1'b0;
    logic [31:0]   rd_data;
    logic          misalign;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [BYTES];

    always #10 clk = ~clk;

    be_data_mem #(.ADDR_W(AW)) i_be_data_mem (
        .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .wr_en(wr_en),
        .wr_data(wr_data), .sext(sext), .rd_data(rd_data), .misalign(misalign)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one request: drive at a falling edge, predict, compare at the next falling edge
    task automatic step(input int a, input logic [1:0] sz, input logic we,
                        input logic [31:0] wd, input logic sx, input bit chk_rd,
                        input string tag);
        logic        bad;
        logic [31:0] exp;
        int          b;
        addr    = a[AW-1:0];
        size    = sz;
        wr_en   = we;
        wr_data = wd;
        sext    = sx;
        b   = a % BYTES;
        bad = (sz == 2'b01 && b[0]) || (sz == 2'b10 && b[1:0] != 2'b00) || sz == 2'b11;
        exp = 32'h0;
        if (!bad) begin
            case (sz)
                2'b00: exp = sx ? {{24{ref_mem[b][7]}}, ref_mem[b]} : {24'h0, ref_mem[b]};
                2'b01: exp = sx ? {{16{ref_mem[b][7]}}, ref_mem[b], ref_mem[b+1]}
                                : {16'h0, ref_mem[b], ref_mem[b+1]};
                default: exp = {ref_mem[b], ref_mem[b+1], ref_mem[b+2], ref_mem[b+3]};
            endcase
            if (we) begin
                case (sz)
                    2'b00: ref_mem[b] = wd[7:0];
                    2'b01: begin ref_mem[b] = wd[15:8]; ref_mem[b+1] = wd[7:0]; end
                    default: begin
                        ref_mem[b] = wd[31:24]; ref_mem[b+1] = wd[23:16];
                        ref_mem[b+2] = wd[15:8]; ref_mem[b+3] = wd[7:0];
                    end
                endcase
            end
        end
        @(negedge clk);
        check(tag, "misalign", {31'h0, misalign}, {31'h0, bad});
        if (chk_rd) check(tag, "rd_data", rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", "rd_data", rd_data, 32'h0);
            check("R1", "misalign", {31'h0, misalign}, 32'h0);
        end
        rst_n = 1'b1;

        // fill every word; read data is unknown, so only the flag is compared
        for (int w = 0; w < BYTES / 4; w++)
            step(w * 4, 2'b10, 1'b1, 32'h5A3C9617 ^ (w * 32'h01030507), 1'b0, 1'b0, "R2");

        // R6: byte stores build AA 15 13 FF at 0..3
        step(0, 2'b00, 1'b1, 32'h123456AA, 1'b0, 1'b1, "R6");
        step(1, 2'b00, 1'b1, 32'h00000015, 1'b0, 1'b1, "R6");
        step(2, 2'b00, 1'b1, 32'hFFFFFF13, 1'b0, 1'b1, "R6");
        step(3, 2'b00, 1'b1, 32'h000000FF, 1'b0, 1'b1, "R6");
        step(0, 2'b10, 1'b0, 32'h0, 1'b0, 1'b1, "R2");
        check("R2", "word example", rd_data, 32'hAA1513FF);
        step(0, 2'b01, 1'b0, 32'h0, 1'b0, 1'b1, "R3");
        check("R3", "half at 0", rd_data, 32'h0000AA15);
        step(2, 2'b01, 1'b0, 32'h0, 1'b0, 1'b1, "R3");
        check("R3", "half at 2", rd_data, 32'h000013FF);
        for (int i = 0; i < 4; i++) step(i, 2'b00, 1'b0, 32'h0, 1'b0, 1'b1, "R4");
        // R5: extension
        step(0, 2'b00, 1'b0, 32'h0, 1'b1, 1'b1, "R5");
        check("R5", "byte sext", rd_data, 32'hFFFFFFAA);
        step(1, 2'b00, 1'b0, 32'h0, 1'b1, 1'b1, "R5");
        step(0, 2'b01, 1'b0, 32'h0, 1'b1, 1'b1, "R5");
        check("R5", "half sext", rd_data, 32'hFFFFAA15);
        step(2, 2'b01, 1'b0, 32'h0, 1'b1, 1'b1, "R5");
        step(0, 2'b10, 1'b0, 32'h0, 1'b1, 1'b1, "R5");

        // R7: half stores leave the other half intact
        step(18, 2'b01, 1'b1, 32'hDEAD8001, 1'b0, 1'b1, "R7");
        step(16, 2'b10, 1'b0, 32'h0, 1'b0, 1'b1, "R7");
        step(20, 2'b01, 1'b1, 32'h0000C3A5, 1'b0, 1'b1, "R7");
        step(20, 2'b10, 1'b0, 32'h0, 1'b0, 1'b1, "R7");

        // R8 and R9: misaligned and reserved stores change nothing
        step(33, 2'b01, 1'b1, 32'h0000EEEE, 1'b1, 1'b1, "R8");
        step(35, 2'b01, 1'b1, 32'h0000EEEE, 1'b0, 1'b1, "R8");
        step(37, 2'b10, 1'b1, 32'hEEEEEEEE, 1'b0, 1'b1, "R8");
        step(38, 2'b10, 1'b1, 32'hEEEEEEEE, 1'b0, 1'b1, "R8");
        step(32, 2'b11, 1'b1, 32'hEEEEEEEE, 1'b0, 1'b1, "R8");
        step(32, 2'b10, 1'b0, 32'h0, 1'b0, 1'b1, "R9");
        step(36, 2'b10, 1'b0, 32'h0, 1'b0, 1'b1, "R9");
        step(40, 2'b10, 1'b0, 32'h0, 1'b0, 1'b1, "R9");

        // R10: back-to-back stores to one word return the prior contents
        step(64, 2'b10, 1'b1, 32'h11112222, 1'b0, 1'b1, "R10");
        step(64, 2'b10, 1'b1, 32'h33334444, 1'b0, 1'b1, "R10");
        check("R10", "old value", rd_data, 32'h11112222);
        step(65, 2'b00, 1'b1, 32'h00000099, 1'b0, 1'b1, "R10");
        step(64, 2'b10, 1'b0, 32'h0, 1'b0, 1'b1, "R10");
        check("R10", "after byte", rd_data, 32'h33994444);

        // R11: top aligned word
        step(BYTES - 4, 2'b10, 1'b1, 32'hCAFEF00D, 1'b0, 1'b1, "R11");
        step(BYTES - 4, 2'b10, 1'b0, 32'h0, 1'b0, 1'b1, "R11");
        check("R11", "top word", rd_data, 32'hCAFEF00D);
        step(BYTES - 1, 2'b00, 1'b0, 32'h0, 1'b1, 1'b1, "R11");

        // mixed traffic
        for (int i = 0; i < 600; i++)
            step($urandom_range(0, BYTES - 1), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)),
                 1'b1, "R2");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule